// File: doc/BRIEF.md
# Multidrop Address Filter and Transceiver Direction Control

This block sits beside a UART's receive and transmit shifters and adds the behaviour a half-duplex multidrop bus needs. On the receive side, the shifter hands over each finished character as a byte plus a ninth bit. In multidrop mode, that ninth bit marks the byte as a station address instead of data. The block decides whether each character is written to the receive FIFO. An address byte that is written raises a one-cycle address event, which the surrounding UART reports as its parity-error status and interrupt. With automatic address filtering on, address bytes are compared with an 8-bit match value. The result opens or closes a listen state, and that state then gates the data bytes that follow.

On the transmit side, the block drives the transceiver's direction line on either the RTS or the DTR pin. The line is asserted while the transmitter has anything to send. After the final stop bit it is held for a programmable number of bit times, counted on the baud tick, and is then released. A polarity control swaps the asserted and released levels. Whichever modem pin is not carrying direction passes its manual level straight through.

Top module: `rs485_link_ctl`

## Requirements
- R1: With multidrop off and the receiver not blocked, every byte presented with `rx_valid` appears on `fifo_data` with `fifo_wr` high in the following cycle. `addr_evt` stays low, whatever the ninth bit is.
- R2: While `rx_block` is 1, no byte reaches the FIFO. The one exception is an address byte that matches in automatic-filter mode.
- R3: With multidrop on and automatic filtering off, a byte with ninth bit 1 is written to the FIFO (if not blocked) and `addr_evt` pulses high in the same cycle as its `fifo_wr`.
- R4: In automatic-filter mode (multidrop and filter both on), an address byte equal to `match_addr` is written with `addr_evt` high, and `rx_listen` becomes 1 in the cycle after it is presented.
- R5: In automatic-filter mode, an address byte that differs from `match_addr` is discarded with no `addr_evt`, and `rx_listen` becomes 0. Data bytes (ninth bit 0) are discarded while `rx_listen` is 0.
- R6: In automatic-filter mode, data bytes are written while `rx_listen` is 1 and `rx_block` is 0. `rx_listen` is 0 after reset and changes only on address bytes received in automatic-filter mode.
- R7: The direction line is asserted in the cycle after transmit data is seen pending (`tx_empty` low or `tx_busy` high). Asserted drives logic 0 and released drives logic 1 when `dir_invert` is 0. Both levels are swapped when `dir_invert` is 1.
- R8: Once the transmitter goes idle (`tx_empty` high and `tx_busy` low), the line stays asserted until `release_dly` baud ticks have been seen, and is released in the cycle after the last of them. With `release_dly` 0 it is released in the cycle after idle is seen.
- R9: Pending transmit data during the release delay cancels the delay. The line stays asserted, and a fresh full delay is counted after the next idle.
- R10: With `auto_dir_en` 1, `dir_sel_dtr` 0 puts the direction level on `rts_out` and 1 puts it on `dtr_out`. The other pin follows its manual input. With `auto_dir_en` 0, both pins follow their manual inputs.
- R11: After reset, `fifo_wr`, `addr_evt` and `rx_listen` are 0 and the direction line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| multidrop_en | input | 1 | Treat the ninth bit as the address marker |
| auto_addr_en | input | 1 | Filter by address compare (with multidrop on) |
| rx_block | input | 1 | Receiver disable |
| match_addr | input | DATA_W | Station address to compare against |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | DATA_W | Received byte |
| rx_ninth | input | 1 | Received ninth bit (address marker) |
| fifo_wr | output | 1 | Write strobe into the receive FIFO |
| fifo_data | output | DATA_W | Byte to write |
| addr_evt | output | 1 | Address byte accepted (parity-error status/interrupt source) |
| rx_listen | output | 1 | Listen state of the automatic filter |
| auto_dir_en | input | 1 | Drive the direction line on a modem pin |
| dir_sel_dtr | input | 1 | 0: direction on RTS, 1: direction on DTR |
| dir_invert | input | 1 | Swap asserted/released levels |
| release_dly | input | DLY_W | Bit times to hold after the last stop bit |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_empty | input | 1 | Transmit FIFO is empty |
| baud_tick | input | 1 | One pulse per bit time |
| rts_manual | input | 1 | Manual RTS level |
| dtr_manual | input | 1 | Manual DTR level |
| rts_out | output | 1 | RTS pin |
| dtr_out | output | 1 | DTR pin |

## Verification
The bench builds the block with the defaults `DATA_W` = 8 and `DLY_W` = 8, so address compares span the full byte range, including 0xFF against a neighbour that differs only in bit 0. With the hold delay set to 3 bit times, the tick-by-tick release, the cancel and restart of the hold, and the zero-delay release can all be reached in a few dozen cycles. Both pin selections and both polarities are driven, each against a manual level chosen to differ from the direction level.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;

  // Pin level of the direction line: asserted is low unless inverted.
  function automatic logic dir_pin_level(input logic asserted, input logic invert);
    return invert ? asserted : ~asserted;
  endfunction

endpackage

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              multidrop_en,
  input  logic              auto_addr_en,
  input  logic              rx_block,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  output logic              wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              addr_evt,
  output logic              listen
);

  function automatic logic addr_hit(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  logic is_addr, auto_mode, hit, accept;
  logic wr_q, evt_q, listen_q;
  logic [DATA_W-1:0] data_q;

  assign is_addr   = multidrop_en & rx_ninth;
  assign auto_mode = multidrop_en & auto_addr_en;
  assign hit       = is_addr & addr_hit(rx_data, match_addr);

  always_comb begin
    if (!rx_valid)      accept = 1'b0;
    else if (auto_mode) accept = is_addr ? hit : (listen_q & ~rx_block);
    else                accept = ~rx_block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      evt_q    <= 1'b0;
      listen_q <= 1'b0;
      data_q   <= '0;
    end else begin
      wr_q  <= accept;
      evt_q <= accept & is_addr;
      if (accept) data_q <= rx_data;
      if (rx_valid && auto_mode && is_addr) listen_q <= hit;
    end
  end

  assign wr       = wr_q;
  assign wr_data  = data_q;
  assign addr_evt = evt_q;
  assign listen   = listen_q;

endmodule

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl
  import rs485_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_busy,
  input  logic             tx_empty,
  input  logic             baud_tick,
  input  logic [DLY_W-1:0] release_dly,
  output logic             asserted
);

  localparam int CNT_W = DLY_W + 1;

  function automatic logic hold_done(input logic [DLY_W-1:0] cnt, input logic [DLY_W-1:0] dly);
    logic [CNT_W-1:0] next_cnt;
    next_cnt = {1'b0, cnt} + CNT_W'(1);
    return (dly == '0) || (next_cnt >= {1'b0, dly});
  endfunction

  dir_state_e state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic pending;

  assign pending = ~tx_empty | tx_busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      DIR_IDLE: if (pending) state_d = DIR_SEND;
      DIR_SEND: if (!pending) begin
        cnt_d   = '0;
        state_d = (release_dly == '0) ? DIR_IDLE : DIR_HOLD;
      end
      DIR_HOLD: begin
        if (pending) state_d = DIR_SEND;
        else if (baud_tick) begin
          if (hold_done(cnt_q, release_dly)) state_d = DIR_IDLE;
          else cnt_d = cnt_q + DLY_W'(1);
        end
      end
      default: state_d = DIR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign asserted = (state_q != DIR_IDLE);

endmodule

// File: rtl/rs485_link_ctl.sv
module rs485_link_ctl
  import rs485_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              multidrop_en,
  input  logic              auto_addr_en,
  input  logic              rx_block,
  input  logic [DATA_W-1:0] match_addr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              addr_evt,
  output logic              rx_listen,
  input  logic              auto_dir_en,
  input  logic              dir_sel_dtr,
  input  logic              dir_invert,
  input  logic [DLY_W-1:0]  release_dly,
  input  logic              tx_busy,
  input  logic              tx_empty,
  input  logic              baud_tick,
  input  logic              rts_manual,
  input  logic              dtr_manual,
  output logic              rts_out,
  output logic              dtr_out
);

  logic dir_asserted;
  logic dir_level;

  rs485_addr_filter #(.DATA_W(DATA_W)) u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .multidrop_en (multidrop_en),
    .auto_addr_en (auto_addr_en),
    .rx_block     (rx_block),
    .match_addr   (match_addr),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ninth     (rx_ninth),
    .wr           (fifo_wr),
    .wr_data      (fifo_data),
    .addr_evt     (addr_evt),
    .listen       (rx_listen)
  );

  rs485_dir_ctl #(.DLY_W(DLY_W)) u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_busy     (tx_busy),
    .tx_empty    (tx_empty),
    .baud_tick   (baud_tick),
    .release_dly (release_dly),
    .asserted    (dir_asserted)
  );

  assign dir_level = dir_pin_level(dir_asserted, dir_invert);

  always_comb begin
    rts_out = rts_manual;
    dtr_out = dtr_manual;
    if (auto_dir_en) begin
      if (dir_sel_dtr) dtr_out = dir_level;
      else             rts_out = dir_level;
    end
  end

endmodule

// File: rtl/rs485_link_chk.sv
module rs485_link_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              multidrop_en,
  input logic              auto_addr_en,
  input logic              rx_block,
  input logic [DATA_W-1:0] match_addr,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ninth,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              addr_evt,
  input logic              rx_listen,
  input logic              auto_dir_en,
  input logic              dir_sel_dtr,
  input logic              tx_busy,
  input logic              tx_empty,
  input logic              dir_asserted,
  input logic              rts_manual,
  input logic              dtr_manual,
  input logic              rts_out,
  input logic              dtr_out
);

  // R1
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !multidrop_en && !rx_block) |=> (fifo_wr && !addr_evt && fifo_data == $past(rx_data)));

  // R2
  blocked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_block && !(multidrop_en && auto_addr_en && rx_ninth)) |=> !fifo_wr);

  // R3
  addr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && multidrop_en && !auto_addr_en && rx_ninth && !rx_block) |=> (fifo_wr && addr_evt));

  // R3
  evt_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt |-> fifo_wr);

  // R5
  mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && multidrop_en && auto_addr_en && rx_ninth && rx_data != match_addr)
      |=> (!fifo_wr && !addr_evt && !rx_listen));

  // R4
  match_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && multidrop_en && auto_addr_en && rx_ninth && rx_data == match_addr)
      |=> (fifo_wr && addr_evt && rx_listen));

  // R7
  assert_on_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty || tx_busy) |=> dir_asserted);

  // R10
  manual_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_dir_en |-> (rts_out == rts_manual && dtr_out == dtr_manual));

  // R10
  other_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en |-> (dir_sel_dtr ? (rts_out == rts_manual) : (dtr_out == dtr_manual)));

endmodule

bind rs485_link_ctl rs485_link_chk #(.DATA_W(DATA_W)) u_link_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .multidrop_en (multidrop_en),
  .auto_addr_en (auto_addr_en),
  .rx_block     (rx_block),
  .match_addr   (match_addr),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_ninth     (rx_ninth),
  .fifo_wr      (fifo_wr),
  .fifo_data    (fifo_data),
  .addr_evt     (addr_evt),
  .rx_listen    (rx_listen),
  .auto_dir_en  (auto_dir_en),
  .dir_sel_dtr  (dir_sel_dtr),
  .tx_busy      (tx_busy),
  .tx_empty     (tx_empty),
  .dir_asserted (dir_asserted),
  .rts_manual   (rts_manual),
  .dtr_manual   (dtr_manual),
  .rts_out      (rts_out),
  .dtr_out      (dtr_out)
);

// File: tb/test_rs485_link_ctl.sv
module test_rs485_link_ctl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       multidrop_en = 1'b0, auto_addr_en = 1'b0, rx_block = 1'b0;
  logic [7:0] match_addr = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ninth = 1'b0;
  logic       fifo_wr, addr_evt, rx_listen;
  logic [7:0] fifo_data;
  logic       auto_dir_en = 1'b1, dir_sel_dtr = 1'b0, dir_invert = 1'b0;
  logic [7:0] release_dly = 8'd3;
  logic       tx_busy = 1'b0, tx_empty = 1'b1, baud_tick = 1'b0;
  logic       rts_manual = 1'b0, dtr_manual = 1'b1;
  logic       rts_out, dtr_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       addr;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_link_ctl i_rs485_link_ctl (
    .clk(clk), .rst_n(rst_n), .multidrop_en(multidrop_en), .auto_addr_en(auto_addr_en),
    .rx_block(rx_block), .match_addr(match_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .addr_evt(addr_evt),
    .rx_listen(rx_listen), .auto_dir_en(auto_dir_en), .dir_sel_dtr(dir_sel_dtr),
    .dir_invert(dir_invert), .release_dly(release_dly), .tx_busy(tx_busy),
    .tx_empty(tx_empty), .baud_tick(baud_tick), .rts_manual(rts_manual),
    .dtr_manual(dtr_manual), .rts_out(rts_out), .dtr_out(dtr_out)
  );

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every FIFO write.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (addr_evt && !fifo_wr) begin
        compared++; mismatched++;
        $display("FAIL R3 addr_evt without write: actual 1 expected 0");
      end
      if (fifo_wr) begin
        compared++;
        if (sb_q.size() == 0) begin
          mismatched++;
          $display("FAIL R2/R5 unexpected write: actual %h expected none", fifo_data);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (fifo_data !== e.data || addr_evt !== e.addr) begin
            mismatched++;
            $display("FAIL %s write: actual %h/%b expected %h/%b", e.req, fifo_data, addr_evt, e.data, e.addr);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic drive_edge(); @(posedge clk); #1; endtask
  task automatic settle(); @(posedge clk); @(negedge clk); endtask

  task automatic expect_byte(input logic [7:0] d, input logic a, input string req);
    exp_t e;
    e.data = d; e.addr = a; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic send(input logic [7:0] d, input logic ninth);
    drive_edge();
    rx_valid = 1'b1; rx_data = d; rx_ninth = ninth;
    drive_edge();
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    drive_edge(); baud_tick = 1'b1;
    drive_edge(); baud_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: values during and just after reset
    check_bit("R11", "rts released in reset", rts_out, 1'b1);
    rst_n = 1'b1;
    settle();
    check_bit("R11", "fifo_wr", fifo_wr, 1'b0);
    check_bit("R11", "addr_evt", addr_evt, 1'b0);
    check_bit("R11", "rx_listen", rx_listen, 1'b0);
    check_bit("R11", "rts released", rts_out, 1'b1);
    check_bit("R10", "dtr manual", dtr_out, 1'b1);

    // R7: assert on pending data, normal polarity on RTS
    drive_edge(); tx_empty = 1'b0;
    settle();
    check_bit("R7", "rts asserted low", rts_out, 1'b0);
    drive_edge(); tx_empty = 1'b1; tx_busy = 1'b1;
    drive_edge(); tx_busy = 1'b0;
    settle();
    check_bit("R8", "held after idle", rts_out, 1'b0);
    tick(); settle(); check_bit("R8", "held after tick 1", rts_out, 1'b0);
    tick(); settle(); check_bit("R8", "held after tick 2", rts_out, 1'b0);
    tick(); settle(); check_bit("R8", "released after tick 3", rts_out, 1'b1);

    // R9: new data during the hold cancels it
    drive_edge(); tx_busy = 1'b1;
    settle(); check_bit("R9", "asserted again", rts_out, 1'b0);
    drive_edge(); tx_busy = 1'b0;
    tick();
    drive_edge(); tx_empty = 1'b0;
    tick(); tick(); tick();
    settle(); check_bit("R9", "kept while pending", rts_out, 1'b0);
    drive_edge(); tx_empty = 1'b1;
    tick(); tick();
    settle(); check_bit("R9", "full delay restarted", rts_out, 1'b0);
    tick();
    settle(); check_bit("R9", "released after restart", rts_out, 1'b1);

    // R8: zero delay
    drive_edge(); release_dly = 8'd0; tx_busy = 1'b1;
    settle(); check_bit("R8", "asserted dly0", rts_out, 1'b0);
    drive_edge(); tx_busy = 1'b0;
    settle(); check_bit("R8", "released dly0", rts_out, 1'b1);

    // R10 + R7: inverted polarity on DTR
    drive_edge(); dir_invert = 1'b1; dir_sel_dtr = 1'b1; rts_manual = 1'b1;
    settle();
    check_bit("R10", "rts manual", rts_out, 1'b1);
    check_bit("R7", "dtr released inverted", dtr_out, 1'b0);
    drive_edge(); tx_empty = 1'b0;
    settle(); check_bit("R7", "dtr asserted inverted", dtr_out, 1'b1);
    drive_edge(); tx_empty = 1'b1;
    settle(); check_bit("R8", "dtr released dly0", dtr_out, 1'b0);

    // R10: automatic direction off
    drive_edge(); auto_dir_en = 1'b0; tx_empty = 1'b0; rts_manual = 1'b0;
    settle();
    check_bit("R10", "rts manual when off", rts_out, 1'b0);
    check_bit("R10", "dtr manual when off", dtr_out, 1'b1);
    drive_edge(); tx_empty = 1'b1;

    // R1: plain mode, ninth bit has no address meaning
    expect_byte(8'h3C, 1'b0, "R1"); send(8'h3C, 1'b0);
    expect_byte(8'hA5, 1'b0, "R1"); send(8'hA5, 1'b1);
    // R2: receiver blocked
    drive_edge(); rx_block = 1'b1;
    send(8'h11, 1'b0);
    settle(); check_bit("R2", "no write while blocked", fifo_wr, 1'b0);
    drive_edge(); rx_block = 1'b0;

    // R3: multidrop without filtering
    drive_edge(); multidrop_en = 1'b1;
    expect_byte(8'h42, 1'b1, "R3"); send(8'h42, 1'b1);
    expect_byte(8'h07, 1'b0, "R3"); send(8'h07, 1'b0);
    settle(); check_bit("R6", "listen untouched outside auto", rx_listen, 1'b0);

    // R4/R5/R6: automatic filtering
    drive_edge(); auto_addr_en = 1'b1; match_addr = 8'h5A;
    send(8'h99, 1'b0);
    settle(); check_bit("R5", "data dropped while closed", rx_listen, 1'b0);
    expect_byte(8'h5A, 1'b1, "R4"); send(8'h5A, 1'b1);
    check_bit("R4", "listen opened", rx_listen, 1'b1);
    expect_byte(8'h12, 1'b0, "R6"); send(8'h12, 1'b0);
    expect_byte(8'h34, 1'b0, "R6"); send(8'h34, 1'b0);
    drive_edge(); rx_block = 1'b1;
    send(8'h56, 1'b0);
    settle(); check_bit("R2", "open but blocked", fifo_wr, 1'b0);
    drive_edge(); rx_block = 1'b0;
    send(8'h77, 1'b1);
    check_bit("R5", "listen closed", rx_listen, 1'b0);
    send(8'h21, 1'b0);
    settle(); check_bit("R5", "data after mismatch", fifo_wr, 1'b0);

    // R4/R5: full-range address, neighbour differs in bit 0
    drive_edge(); match_addr = 8'hFF;
    send(8'hFE, 1'b1);
    check_bit("R5", "FE vs FF rejected", rx_listen, 1'b0);
    expect_byte(8'hFF, 1'b1, "R4"); send(8'hFF, 1'b1);
    check_bit("R4", "FF matched", rx_listen, 1'b1);
    expect_byte(8'h00, 1'b0, "R6"); send(8'h00, 1'b0);

    repeat (4) settle();
    check_bit("R6", "scoreboard drained", sb_q.size() == 0, 1'b1);
    finish_run();
  end

endmodule